// File: doc/BRIEF.md
# GPIO Port Direction-Override Controller

This block is an 8-bit general-purpose I/O port. Software programs a direction register and a data register over a small register interface. Each pin's pad controls are resolved bit by bit from three sources. An LCD segment enable has the highest priority. A timer output-compare enable comes next. The software direction bit has the lowest priority.

Two timer instances share the port. Timer A owns the upper nibble and timer B owns the lower nibble. Their compare enables and compare levels arrive as plain vectors. Pin levels reach the register read path through a two-stage synchronizer. Because of this, a read of the pin level lags a change at the pad by two clock edges.

The register interface uses a 2-bit address, a write strobe and byte-wide write and read data. Reads are combinational from the address. Writes take effect on the next rising clock edge.

Top module: `gpio_dir_ovr`

## Requirements
- R1: After reset the direction and data registers hold 0x00, so pad_oe_o is 0x00, pad_ie_o is 0xFF and pad_do_o is 0x00.
- R2: The direction register at address 2 can be written at any time, including while overrides are active. The write takes effect at the next rising edge. A read returns the stored bits, not the effective directions.
- R3: For a pin with no LCD or timer override, direction bit 1 sets pad_oe_o to 1 and direction bit 0 sets it to 0. In both cases pad_do_o carries the data register bit and pad_ie_o is 1.
- R4: When lcd_en_i is 1 for a pin, pad_oe_o, pad_ie_o and pad_do_o are all 0 for that pin, whatever the timer enables and the direction bit say.
- R5: When lcd_en_i is 0 and the timer compare enable for a pin is 1, pad_oe_o is 1 and pad_do_o carries the timer compare level. Port bits 7..4 take tma bits 3..0, and port bits 3..0 take tmb bits 3..0.
- R6: The pin input register at address 1 returns the pad level two rising edges after the pad changes, and still the old level after one edge. LCD pins read 0. Writes to address 1 are ignored.
- R7: A read of the data register at address 0 returns, per bit, the data register bit when the pin's effective direction is output. For an input pin it returns the synchronized pad level, and for an LCD pin it returns 0.
- R8: Address 3 is reserved. It always reads 0x00, and a write to it changes neither the direction register nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 data, 1 pin input, 2 direction, 3 reserved |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| lcd_en_i | input | 8 | Per-pin LCD segment enable |
| tma_en_i | input | 4 | Timer A compare enables for port bits 7..4 |
| tma_oc_i | input | 4 | Timer A compare levels for port bits 7..4 |
| tmb_en_i | input | 4 | Timer B compare enables for port bits 3..0 |
| tmb_oc_i | input | 4 | Timer B compare levels for port bits 3..0 |
| pad_in_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Pad output enables |
| pad_ie_o | output | 8 | Pad input enables |
| pad_do_o | output | 8 | Pad output data |

## Verification
The pad controls are combinational from the override inputs and the registers. They are therefore sampled 1 ns after the inputs change, with no clock edge in between. A register write is driven at a falling edge and read back after the next rising edge, one cycle later.

Pad-to-readback results are due two rising edges after the pad changes. The bench reads once after the first edge to confirm the old level is still present, and again after the second edge for the new one. Every sample is taken away from the rising edge.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;
  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_PIN  = 2'd1,
    RA_DIR  = 2'd2,
    RA_RSV  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve (
  input  logic lcd_i,
  input  logic oc_en_i,
  input  logic oc_i,
  input  logic dir_i,
  input  logic dat_i,
  output logic oe_o,
  output logic ie_o,
  output logic do_o,
  output logic eff_out_o
);
  // priority: LCD disable > timer force > software direction
  always_comb begin
    if (lcd_i) begin
      oe_o = 1'b0;
      ie_o = 1'b0;
      do_o = 1'b0;
    end else if (oc_en_i) begin
      oe_o = 1'b1;
      ie_o = 1'b1;
      do_o = oc_i;
    end else begin
      oe_o = dir_i;
      ie_o = 1'b1;
      do_o = dat_i;
    end
  end

  assign eff_out_o = oe_o;
endmodule

// File: rtl/gpio_dir_ovr.sv
module gpio_dir_ovr
  import gpio_dir_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int LO_BITS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 addr_i,
  input  logic                       we_i,
  input  logic [WIDTH-1:0]           wdata_i,
  output logic [WIDTH-1:0]           rdata_o,
  input  logic [WIDTH-1:0]           lcd_en_i,
  input  logic [WIDTH-LO_BITS-1:0]   tma_en_i,
  input  logic [WIDTH-LO_BITS-1:0]   tma_oc_i,
  input  logic [LO_BITS-1:0]         tmb_en_i,
  input  logic [LO_BITS-1:0]         tmb_oc_i,
  input  logic [WIDTH-1:0]           pad_in_i,
  output logic [WIDTH-1:0]           pad_oe_o,
  output logic [WIDTH-1:0]           pad_ie_o,
  output logic [WIDTH-1:0]           pad_do_o
);
  localparam int HI_BITS = WIDTH - LO_BITS;

  logic [WIDTH-1:0] dir_q, dat_q, pin_sync, eff_out;
  logic [WIDTH-1:0] oc_en, oc_lvl;

  assign oc_en  = {tma_en_i, tmb_en_i};
  assign oc_lvl = {tma_oc_i, tmb_oc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (we_i) begin
      if (addr_i == RA_DIR)  dir_q <= wdata_i;
      if (addr_i == RA_DATA) dat_q <= wdata_i;
    end
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_resolve u_res (
      .lcd_i     (lcd_en_i[i]),
      .oc_en_i   (oc_en[i]),
      .oc_i      (oc_lvl[i]),
      .dir_i     (dir_q[i]),
      .dat_i     (dat_q[i]),
      .oe_o      (pad_oe_o[i]),
      .ie_o      (pad_ie_o[i]),
      .do_o      (pad_do_o[i]),
      .eff_out_o (eff_out[i])
    );
  end

  logic [WIDTH-1:0] pin_vis;
  assign pin_vis = pin_sync & pad_ie_o;

  always_comb begin
    unique case (addr_i)
      RA_DATA: rdata_o = (eff_out & dat_q) | (~eff_out & pin_vis);
      RA_PIN:  rdata_o = pin_vis;
      RA_DIR:  rdata_o = dir_q;
      default: rdata_o = '0;
    endcase
  end

  AST_LCD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_en_i & (pad_oe_o | pad_ie_o | pad_do_o)) == '0); // R4
  AST_TMR_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_en & ~lcd_en_i & ~pad_oe_o) == '0); // R5
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_DIR) |=> dir_q == $past(wdata_i)); // R2
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RA_RSV) |-> rdata_o == '0); // R8
  AST_RSV_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_RSV) |=> ($stable(dir_q) && $stable(dat_q))); // R8
  AST_HI_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_en_i[WIDTH-1] == 1'b0 && tma_en_i[HI_BITS-1]) |->
      pad_do_o[WIDTH-1] == tma_oc_i[HI_BITS-1]); // R5
endmodule

// File: tb/gpio_dir_ovr_tb_top.sv
module gpio_dir_ovr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic we = 1'b0;
  logic [7:0] wdata = '0, rdata, lcd = '0, ext = '0;
  logic [3:0] ta_en = '0, ta = '0, tb_en = '0, tb = '0;
  logic [7:0] oe, ie, dout, pad;
  int total = 0, bad = 0;

  always #4 clk = ~clk;
  assign pad = (oe & dout) | (~oe & ext);

  gpio_dir_ovr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .lcd_en_i(lcd), .tma_en_i(ta_en), .tma_oc_i(ta),
    .tmb_en_i(tb_en), .tmb_oc_i(tb), .pad_in_i(pad), .pad_oe_o(oe),
    .pad_ie_o(ie), .pad_do_o(dout)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // {lcd, ta_en, ta, tb_en, tb, dir, data, exp_oe, exp_ie, exp_do}
  localparam logic [63:0] VEC [7] = '{
    {8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 8'hFF, 8'hA5, 8'hFF, 8'hFF, 8'hA5},
    {8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 8'h0F, 8'hFF, 8'h0F, 8'hFF, 8'hFF},
    {8'h00, 4'hF, 4'hA, 4'h0, 4'h0, 8'h00, 8'h00, 8'hF0, 8'hFF, 8'hA0},
    {8'h00, 4'h0, 4'h0, 4'h5, 4'h4, 8'h00, 8'h03, 8'h05, 8'hFF, 8'h06},
    {8'hF0, 4'hF, 4'hF, 4'hF, 4'hF, 8'hFF, 8'hFF, 8'h0F, 8'h0F, 8'h0F},
    {8'h81, 4'h8, 4'h8, 4'h1, 4'h1, 8'h42, 8'h42, 8'h42, 8'h7E, 8'h42},
    {8'h3C, 4'h0, 4'h0, 4'h0, 4'h0, 8'hFF, 8'hFF, 8'hC3, 8'hC3, 8'hC3}
  };

  initial begin
    #(8 * 50000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #20; rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 8'h00);
    chk("R1 ie", ie, 8'hFF);
    chk("R1 do", dout, 8'h00);
    rd(2'd2, r); chk("R1 dir", r, 8'h00);
    rd(2'd0, r); chk("R1 data", r, 8'h00);

    // R3 R4 R5 vector walk
    for (int v = 0; v < 7; v++) begin
      logic [63:0] e;
      e = VEC[v];
      lcd = '0; ta_en = '0; tb_en = '0;
      wr(2'd2, e[39:32]);
      wr(2'd0, e[31:24]);
      lcd = e[63:56]; ta_en = e[55:52]; ta = e[51:48]; tb_en = e[47:44]; tb = e[43:40];
      #1;
      chk($sformatf("R3/R4/R5 v%0d oe", v), oe, e[23:16]);
      chk($sformatf("R3/R4/R5 v%0d ie", v), ie, e[15:8]);
      chk($sformatf("R3/R4/R5 v%0d do", v), dout, e[7:0]);
      rd(2'd2, r); chk($sformatf("R2 v%0d dir readback", v), r, e[39:32]);
    end

    // R2 write under override
    lcd = 8'hFF; ta_en = 4'hF; tb_en = 4'hF;
    wr(2'd2, 8'h96);
    rd(2'd2, r); chk("R2 dir write under override", r, 8'h96);
    lcd = '0; ta_en = '0; tb_en = '0;

    // R6 synchronizer latency
    wr(2'd2, 8'h00);
    ext = 8'h00;
    repeat (3) @(negedge clk);
    ext = 8'hFF;
    @(negedge clk); rd(2'd1, r); chk("R6 pin one edge", r, 8'h00);
    @(negedge clk); rd(2'd1, r); chk("R6 pin two edges", r, 8'hFF);
    lcd = 8'h0F; #1;
    rd(2'd1, r); chk("R6 lcd pins read 0", r, 8'hF0);
    lcd = '0;
    wr(2'd1, 8'h00);
    rd(2'd1, r); chk("R6 write ignored", r, 8'hFF);

    // R7 data read mux
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'h5A);
    ext = 8'hA3;
    repeat (3) @(negedge clk);
    rd(2'd0, r); chk("R7 data mixed", r, 8'hAA);
    rd(2'd1, r); chk("R7 pin mixed", r, 8'hAA);
    ext = 8'h5C;
    repeat (3) @(negedge clk);
    rd(2'd0, r); chk("R7 data after change", r, 8'h5A);
    ta_en = 4'hF; ta = 4'h0; #1;
    rd(2'd0, r); chk("R7 timer-forced reads data reg", r, 8'h5A);
    ta_en = '0;

    // R8 reserved slot
    wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R8 reserved reads 0", r, 8'h00);
    rd(2'd2, r); chk("R8 dir unchanged", r, 8'h0F);
    chk("R8 data unchanged via pad", dout, 8'h5A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule